// File: doc/BRIEF.md
# Markup Tag Nesting Checker

This block decides whether a stream of markup tags, already split into tokens upstream, is properly nested. Each token is either an opening tag or a closing tag and carries a fixed-width name field. Shorter names are zero-padded. The block keeps an on-chip stack of open tag names. Opening tags are pushed. A closing tag is compared against the name on top of the stack and, if it matches, that name is popped. A distinguished bottom marker sits under the real entries. When a matching pop exposes the bottom marker again, the document is declared well-formed at once.

A document is framed by a start-of-document strobe. The check can also end early with a malformed verdict for any of these reasons:
- a closing tag that does not match the top of the stack,
- a closing tag while nothing is open,
- an opening tag while the stack is full (this also raises an overflow flag),
- an end-of-stream indication while tags are still open.

Once a verdict is reached, the block pulses done for one cycle. It then refuses tokens and holds its verdict until the next start-of-document strobe.

Top module: `tag_nest_checker`

## Requirements
- R1: After reset, or in the cycle after a start-of-document strobe, ready is high, done, well-formed, malformed and overflow are low, and the stack holds only the bottom marker. The bottom marker is distinct from every name, including the all-zero name.
- R2: Token kind encoding is 0 = opening tag, 1 = closing tag. An accepted opening tag pushes its name. An accepted closing tag whose name equals the top entry pops it. If that pop exposes the bottom marker, well-formed and done are high in the cycle after the token was accepted.
- R3: An accepted closing tag whose name differs from the top entry gives malformed and done in the next cycle.
- R4: An accepted closing tag while only the bottom marker is on the stack gives malformed and done in the next cycle.
- R5: An accepted opening tag while DEPTH names are open gives overflow, malformed and done in the next cycle. Exactly DEPTH open names is not an error.
- R6: After a verdict, ready stays low, and the verdict flags hold their values until the next start-of-document strobe. Tokens presented in that time are ignored.
- R7: End-of-stream while no verdict has been reached gives malformed and done in the next cycle. End-of-stream after a verdict has no effect.
- R8: While no verdict has been reached, one token is accepted per cycle, back to back, with ready held high.
- R9: Done is high for exactly one cycle per verdict. Well-formed and malformed are never high together.
- R10: A start-of-document strobe takes priority over a token or an end-of-stream in the same cycle. ready is low in that cycle and the token is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sod_i | input | 1 | Start-of-document strobe; empties the stack and clears the verdict |
| eos_i | input | 1 | End-of-stream indication |
| tok_valid_i | input | 1 | Token valid |
| tok_ready_o | output | 1 | Token accepted when high together with valid |
| tok_kind_i | input | 1 | 0 = opening tag, 1 = closing tag |
| tok_name_i | input | NAME_W | Tag name, zero-padded |
| done_o | output | 1 | One-cycle pulse when a verdict is reached |
| well_formed_o | output | 1 | Verdict: properly nested |
| malformed_o | output | 1 | Verdict: nesting error |
| overflow_o | output | 1 | Malformed because the stack was full |

## Verification
Every verdict is registered. Done and the flags therefore appear in the cycle right after the edge that accepted the deciding token, strobe or end-of-stream. The driver presents each token just after a rising edge and lets it be consumed at the next one. The monitor samples at the falling edge that follows. A scoreboard queue holds one expected verdict per document. The monitor pops an entry at each done pulse, which catches late, early or missing verdicts. In the same falling-edge sample it also checks that done has fallen one cycle later. Directed samples taken while no verdict is pending, or while a verdict is being held, confirm that ready is at the expected level and that ignored stimulus leaves the flags untouched.

// File: rtl/tag_nest_pkg.sv
// Shared types for the tag nesting checker.
// Assumes names are NAME_W bits; each stack entry adds one marker bit above.
package tag_nest_pkg;

    // Token kind as seen on tok_kind_i.
    typedef enum logic {
        TOK_OPEN  = 1'b0,
        TOK_CLOSE = 1'b1
    } tok_kind_e;

    // Checker phase: scanning tokens, or holding a verdict.
    typedef enum logic {
        PH_SCAN = 1'b0,
        PH_HOLD = 1'b1
    } phase_e;

    // Verdict bundle registered by the controller.
    typedef struct packed {
        logic done;
        logic good;
        logic bad;
        logic ovf;
    } verdict_t;

    localparam verdict_t VERDICT_CLEAR = '{done: 1'b0, good: 1'b0, bad: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/tag_stack.sv
// Tag name stack with a registered top-of-stack copy.
// What it does: holds up to DEPTH names above an implicit bottom marker. The
//   top entry is presented from a register as {marker, name}; the marker bit
//   is 1 only for the bottom marker, so no real name can ever equal it.
// Assumes: push is never requested when full; pop is never requested when
//   empty; clear wins over push and pop.
module tag_stack #(
    parameter int NAME_W = 64,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [NAME_W-1:0] name_i,
    output logic [NAME_W:0]   top_o,
    output logic [PTR_W-1:0]  level_o,
    output logic              full_o,
    output logic              last_o
);

    localparam logic [NAME_W:0]  BOTTOM    = {1'b1, {NAME_W{1'b0}}};
    localparam logic [PTR_W-1:0] LVL_FULL  = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] LVL_ONE   = PTR_W'(1);
    localparam logic [PTR_W-1:0] LVL_TWO   = PTR_W'(2);

    logic [NAME_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  level_q;
    logic [NAME_W:0]   top_q;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  below_idx;
    logic [NAME_W:0]   below_entry;

    // Index of the slot a push writes and of the entry beneath the top.
    always_comb begin
        wr_idx    = IDX_W'(level_q);
        below_idx = IDX_W'(level_q - LVL_TWO);
    end

    // Entry that becomes the top after a pop.
    always_comb begin
        if (level_q >= LVL_TWO) begin
            below_entry = {1'b0, store[below_idx]};
        end else begin
            below_entry = BOTTOM;
        end
    end

    // Storage write on push; contents need no reset since level guards reads.
    always_ff @(posedge clk) begin
        if (push_i && !clear_i) begin
            store[wr_idx] <= name_i;
        end
    end

    // Fill level and registered top-of-stack copy.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            level_q <= '0;
            top_q   <= BOTTOM;
        end else if (push_i) begin
            level_q <= level_q + LVL_ONE;
            top_q   <= {1'b0, name_i};
        end else if (pop_i) begin
            level_q <= level_q - LVL_ONE;
            top_q   <= below_entry;
        end
    end

    // Status outputs.
    always_comb begin
        top_o   = top_q;
        level_o = level_q;
        full_o  = (level_q == LVL_FULL);
        last_o  = (level_q == LVL_ONE);
    end

endmodule

// File: rtl/tag_compare.sv
// Single-cycle equality of an incoming closing-tag name against the top entry.
// What it does: splits the name into LANE_W lanes, compares each lane in
//   parallel and also requires the top entry's marker bit to be clear.
// Assumes: NAME_W is a multiple of LANE_W.
module tag_compare #(
    parameter int NAME_W = 64,
    parameter int LANE_W = 8,
    localparam int LANES = NAME_W / LANE_W
) (
    input  logic [NAME_W-1:0] name_i,
    input  logic [NAME_W:0]   top_i,
    output logic              equal_o
);

    logic [LANES-1:0] lane_eq;

    // Per-lane comparators.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_eq[g] = (name_i[g*LANE_W +: LANE_W] == top_i[g*LANE_W +: LANE_W]);
        end
    end

    // Reduce lanes; a set marker bit means the bottom, which never matches.
    always_comb begin
        equal_o = (&lane_eq) && !top_i[NAME_W];
    end

endmodule

// File: rtl/nest_ctrl.sv
// Control of the nesting checker.
// What it does: accepts tokens while scanning, issues push/pop to the stack,
//   and registers a verdict (good, bad, overflow) plus a one-cycle done pulse.
// Assumes: equal_i, full_i and last_i describe the stack before this cycle's
//   token; a start strobe overrides everything in the same cycle.
module nest_ctrl
    import tag_nest_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sod_i,
    input  logic eos_i,
    input  logic tok_valid_i,
    input  logic tok_kind_i,
    input  logic equal_i,
    input  logic full_i,
    input  logic last_i,
    output logic ready_o,
    output logic push_o,
    output logic pop_o,
    output logic clear_o,
    output verdict_t verdict_o
);

    phase_e   phase_q, phase_d;
    verdict_t vd_q, vd_d;
    logic     take, take_open, take_close;

    // Handshake and token classification.
    always_comb begin
        ready_o    = (phase_q == PH_SCAN) && !sod_i && !eos_i;
        take       = tok_valid_i && ready_o;
        take_open  = take && (tok_kind_i == TOK_OPEN);
        take_close = take && (tok_kind_i == TOK_CLOSE);
        push_o     = take_open && !full_i;
        pop_o      = take_close && equal_i;
        clear_o    = sod_i;
    end

    // Next phase and verdict.
    always_comb begin
        phase_d     = phase_q;
        vd_d        = vd_q;
        vd_d.done   = 1'b0;
        if (sod_i) begin
            phase_d = PH_SCAN;
            vd_d    = VERDICT_CLEAR;
        end else if (phase_q == PH_SCAN) begin
            if (eos_i) begin
                phase_d  = PH_HOLD;
                vd_d.bad = 1'b1;
                vd_d.done = 1'b1;
            end else if (take_open && full_i) begin
                phase_d  = PH_HOLD;
                vd_d.bad = 1'b1;
                vd_d.ovf = 1'b1;
                vd_d.done = 1'b1;
            end else if (take_close && !equal_i) begin
                phase_d  = PH_HOLD;
                vd_d.bad = 1'b1;
                vd_d.done = 1'b1;
            end else if (take_close && last_i) begin
                phase_d   = PH_HOLD;
                vd_d.good = 1'b1;
                vd_d.done = 1'b1;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_SCAN;
            vd_q    <= VERDICT_CLEAR;
        end else begin
            phase_q <= phase_d;
            vd_q    <= vd_d;
        end
    end

    // Registered verdict out.
    always_comb begin
        verdict_o = vd_q;
    end

endmodule

// File: rtl/tag_nest_checker.sv
// Top of the markup tag nesting checker.
// What it does: wires the controller, the name stack and the comparator into
//   a pushdown checker over a valid/ready token stream.
// Assumes: tokens are already lexed; NAME_W is a multiple of 8; DEPTH >= 2.
module tag_nest_checker
    import tag_nest_pkg::*;
#(
    parameter int NAME_W = 64,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sod_i,
    input  logic              eos_i,
    input  logic              tok_valid_i,
    output logic              tok_ready_o,
    input  logic              tok_kind_i,
    input  logic [NAME_W-1:0] tok_name_i,
    output logic              done_o,
    output logic              well_formed_o,
    output logic              malformed_o,
    output logic              overflow_o
);

    logic [NAME_W:0]  top_entry;
    logic [PTR_W-1:0] level;
    logic             full, last, equal;
    logic             push, pop, clear;
    verdict_t         verdict;

    nest_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sod_i       (sod_i),
        .eos_i       (eos_i),
        .tok_valid_i (tok_valid_i),
        .tok_kind_i  (tok_kind_i),
        .equal_i     (equal),
        .full_i      (full),
        .last_i      (last),
        .ready_o     (tok_ready_o),
        .push_o      (push),
        .pop_o       (pop),
        .clear_o     (clear),
        .verdict_o   (verdict)
    );

    tag_stack #(.NAME_W(NAME_W), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .push_i  (push),
        .pop_i   (pop),
        .name_i  (tok_name_i),
        .top_o   (top_entry),
        .level_o (level),
        .full_o  (full),
        .last_o  (last)
    );

    tag_compare #(.NAME_W(NAME_W), .LANE_W(8)) u_cmp (
        .name_i  (tok_name_i),
        .top_i   (top_entry),
        .equal_o (equal)
    );

    // Verdict outputs.
    always_comb begin
        done_o        = verdict.done;
        well_formed_o = verdict.good;
        malformed_o   = verdict.bad;
        overflow_o    = verdict.ovf;
    end

endmodule

// File: rtl/tag_nest_checker_sva.sv
// Property checker for tag_nest_checker, attached with bind.
// What it does: checks verdict timing and hold rules from ports plus the
//   stack's top entry and fill level.
module tag_nest_checker_sva #(
    parameter int NAME_W = 64,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sod_i,
    input logic              eos_i,
    input logic              tok_valid_i,
    input logic              tok_ready_o,
    input logic              tok_kind_i,
    input logic [NAME_W-1:0] tok_name_i,
    input logic              done_o,
    input logic              well_formed_o,
    input logic              malformed_o,
    input logic              overflow_o,
    input logic [NAME_W:0]   top_entry,
    input logic [PTR_W-1:0]  level
);

    // R1
    sod_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sod_i |=> (tok_ready_o || eos_i) && !done_o && !well_formed_o && !malformed_o && !overflow_o);

    // R3
    mismatch_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid_i && tok_ready_o && tok_kind_i && ({1'b0, tok_name_i} != top_entry))
        |=> (malformed_o && done_o));

    // R4
    empty_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid_i && tok_ready_o && tok_kind_i && (level == '0)) |=> malformed_o);

    // R5
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid_i && tok_ready_o && !tok_kind_i && (level == PTR_W'(DEPTH)))
        |=> (overflow_o && malformed_o && done_o));

    // R6
    hold_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (well_formed_o || malformed_o) |-> !tok_ready_o);

    // R6
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((well_formed_o || malformed_o) && !sod_i) |=> ($stable(well_formed_o) && $stable(malformed_o) && $stable(overflow_o)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(well_formed_o && malformed_o));

endmodule

bind tag_nest_checker tag_nest_checker_sva #(.NAME_W(NAME_W), .DEPTH(DEPTH)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .sod_i         (sod_i),
    .eos_i         (eos_i),
    .tok_valid_i   (tok_valid_i),
    .tok_ready_o   (tok_ready_o),
    .tok_kind_i    (tok_kind_i),
    .tok_name_i    (tok_name_i),
    .done_o        (done_o),
    .well_formed_o (well_formed_o),
    .malformed_o   (malformed_o),
    .overflow_o    (overflow_o),
    .top_entry     (top_entry),
    .level         (level)
);

// File: tb/tag_nest_checker_test.sv
// Scoreboard bench for tag_nest_checker: driver queues expected verdicts,
// monitor compares them at each done pulse.
module tag_nest_checker_test;

    localparam int NW = 64;
    localparam int DP = 4;
    localparam logic [NW-1:0] N_A = 64'h61;
    localparam logic [NW-1:0] N_B = 64'h62;
    localparam logic [NW-1:0] N_C = 64'h63;
    localparam logic [NW-1:0] N_BODY = 64'h626f6479;
    localparam logic [NW-1:0] N_ZERO = 64'h0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sod = 1'b0;
    logic          eos = 1'b0;
    logic          tvalid = 1'b0;
    logic          tkind = 1'b0;
    logic [NW-1:0] tname = '0;
    logic          tready, done, wf, mal, ovf;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    typedef struct {
        bit    wf;
        bit    mal;
        bit    ovf;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    tag_nest_checker #(.NAME_W(NW), .DEPTH(DP)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sod_i         (sod),
        .eos_i         (eos),
        .tok_valid_i   (tvalid),
        .tok_ready_o   (tready),
        .tok_kind_i    (tkind),
        .tok_name_i    (tname),
        .done_o        (done),
        .well_formed_o (wf),
        .malformed_o   (mal),
        .overflow_o    (ovf)
    );

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Present one token; consumed at the next rising edge.
    task automatic put(bit kind, logic [NW-1:0] name);
        tvalid = 1'b1;
        tkind  = kind;
        tname  = name;
        @(posedge clk);
        #1;
        tvalid = 1'b0;
    endtask

    task automatic start_doc();
        sod = 1'b1;
        @(posedge clk);
        #1;
        sod = 1'b0;
    endtask

    task automatic expect_verdict(bit w, bit m, bit o, string req);
        exp_t e;
        e.wf = w; e.mal = m; e.ovf = o; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare each done pulse against the queue; check pulse width.
    bit done_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_prev) chk(!done, "R9", "done width", int'(done), 0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(wf == e.wf, e.req, "well_formed", int'(wf), int'(e.wf));
                    chk(mal == e.mal, e.req, "malformed", int'(mal), int'(e.mal));
                    chk(ovf == e.ovf, e.req, "overflow", int'(ovf), int'(e.ovf));
                end
            end
            done_prev <= done;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tready == 1'b1, "R1", "ready after reset", int'(tready), 1);
        chk(!done && !wf && !mal && !ovf, "R1", "flags after reset", int'({done, wf, mal, ovf}), 0);

        // R2 / R8: <a><b><body></body></b></a>, back to back
        put(1'b0, N_A);
        put(1'b0, N_B);
        put(1'b0, N_BODY);
        @(negedge clk);
        chk(tready == 1'b1, "R8", "ready while scanning", int'(tready), 1);
        chk(!done, "R8", "no verdict mid document", int'(done), 0);
        put(1'b1, N_BODY);
        put(1'b1, N_B);
        expect_verdict(1'b1, 1'b0, 1'b0, "R2");
        put(1'b1, N_A);
        settle();

        // R6 / R7: held verdict ignores tokens and end-of-stream
        chk(tready == 1'b0, "R6", "ready after verdict", int'(tready), 0);
        put(1'b0, N_C);
        eos = 1'b1;
        @(posedge clk);
        #1 eos = 1'b0;
        settle();
        chk(wf == 1'b1 && mal == 1'b0, "R7", "verdict held after eos", int'({wf, mal}), 2);
        chk(wf == 1'b1, "R6", "verdict held after token", int'(wf), 1);

        // R1: strobe clears the verdict
        start_doc();
        @(negedge clk);
        chk(tready && !wf && !mal && !ovf, "R1", "state after strobe", int'({tready, wf, mal, ovf}), 8);

        // R3: inner mismatch <a><b><c></c></a>
        put(1'b0, N_A);
        put(1'b0, N_B);
        put(1'b0, N_C);
        put(1'b1, N_C);
        expect_verdict(1'b0, 1'b1, 1'b0, "R3");
        put(1'b1, N_A);
        settle();

        // R4: close on empty stack
        start_doc();
        expect_verdict(1'b0, 1'b1, 1'b0, "R4");
        put(1'b1, N_A);
        settle();

        // R1: all-zero name is a real name, not the bottom marker
        start_doc();
        put(1'b0, N_ZERO);
        expect_verdict(1'b1, 1'b0, 1'b0, "R1");
        put(1'b1, N_ZERO);
        settle();

        // R4: all-zero close on empty stack
        start_doc();
        expect_verdict(1'b0, 1'b1, 1'b0, "R4");
        put(1'b1, N_ZERO);
        settle();

        // R5 boundary: exactly DP open then closed is well-formed
        start_doc();
        for (int i = 0; i < DP; i++) put(1'b0, NW'(64'h41 + i));
        @(negedge clk);
        chk(tready == 1'b1 && !done, "R5", "full stack not an error", int'(tready), 1);
        for (int i = DP - 1; i >= 1; i--) put(1'b1, NW'(64'h41 + i));
        expect_verdict(1'b1, 1'b0, 1'b0, "R5");
        put(1'b1, NW'(64'h41));
        settle();

        // R5: one push beyond DP
        start_doc();
        for (int i = 0; i < DP; i++) put(1'b0, N_A);
        expect_verdict(1'b0, 1'b1, 1'b1, "R5");
        put(1'b0, N_B);
        settle();

        // R7: end-of-stream with tags open
        start_doc();
        put(1'b0, N_A);
        expect_verdict(1'b0, 1'b1, 1'b0, "R7");
        eos = 1'b1;
        @(posedge clk);
        #1 eos = 1'b0;
        settle();

        // R10: strobe with a simultaneous opening tag; tag must not be consumed
        start_doc();
        put(1'b0, N_A);
        sod = 1'b1;
        tvalid = 1'b1;
        tkind = 1'b0;
        tname = N_B;
        @(negedge clk);
        chk(tready == 1'b0, "R10", "ready during strobe", int'(tready), 0);
        @(posedge clk);
        #1;
        sod = 1'b0;
        tvalid = 1'b0;
        expect_verdict(1'b0, 1'b1, 1'b0, "R10");
        put(1'b1, N_B);
        settle();

        chk(exp_q.size() == 0, "R9", "verdicts outstanding", exp_q.size(), 0);
        summary();
    end

endmodule